// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit carries out indivisible memory updates on behalf of a core: fetch-and-add, compare-and-swap and swap. A request names the operation, a plain word address (no offset and no indexing), an operand width, and up to two operand values. The unit reads the addressed word and works out the replacement value. It writes the word back only when the operation calls for a write, then returns the value that memory held before the update.

The memory stays locked from the moment the read is issued until the write, or the decision to skip it, has completed. No second request is accepted until the core has taken the response, so two updates can never interleave. Narrow (32-bit) operations act on the low half of the 64-bit memory word. They leave the upper half intact and return the old low half zero-extended.

The memory port is expected to return read data one cycle after a read strobe and to keep it on `mem_rdata` until the next read.

Top module: `amo_unit`

## Requirements
- R1: Operation code 2'b00 (add) writes old + `req_opa` to the addressed word and returns the old value.
- R2: Operation code 2'b01 (compare-and-swap) writes `req_opb` when the old value equals `req_opa`, and returns the old value.
- R3: A compare-and-swap whose compare fails issues no write, so memory is unchanged, and still returns the old value.
- R4: Operation code 2'b10 (swap) writes `req_opb` and returns the old value.
- R5: With `req_wide`=0, add, compare and replacement use bits [31:0] only. Add wraps modulo 2^32. Bits [63:32] of the memory word are written back unchanged, and the returned value is the old bits [31:0] with zero upper bits.
- R6: Each request issues exactly one read, then at most one write, both at the request address. `mem_lock` is high from the read through the write, and `req_ready` stays low while the lock is held.
- R7: `rsp_valid` and `rsp_data` hold steady until `rsp_ready` is seen high.
- R8: After reset, `req_ready` is 1 and `rsp_valid`, `mem_req` and `mem_lock` are 0.
- R9: Operation code 2'b11 issues no write and returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 2 | Operation code |
| req_wide | input | 1 | 1 = 64-bit, 0 = 32-bit operation |
| req_addr | input | ADDR_W | Word address |
| req_opa | input | DATA_W | Add operand or compare value |
| req_opb | input | DATA_W | Replacement value |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Core takes the response |
| rsp_data | output | DATA_W | Prior memory value |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write access |
| mem_lock | output | 1 | Memory reserved for this unit |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, one cycle after the read |

## Verification
The bench targets a 64-bit add that carries out of bit 31, which a design that truncated wide sums would get wrong. It runs a narrow add that overflows 32 bits: a design that let the carry reach the upper half, or that cleared that half, would leave the wrong word in memory. It also runs a narrow compare-and-swap whose upper halves differ but whose low halves match; a design that compared all 64 bits would fail that swap. Failed compares and the reserved code are counted against the observed write strobes, so a spurious write shows up as a count mismatch. A stalled response exposes a design that dropped or changed its data before `rsp_ready`.

// File: rtl/amo_pkg.sv
package amo_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_CAS = 2'b01,
        OP_SWP = 2'b10,
        OP_RSV = 2'b11
    } amo_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_LATCH,
        ST_WRITE,
        ST_RESP
    } amo_state_e;

    typedef struct packed {
        amo_op_e op;
        logic    wide;
    } amo_cmd_t;

endpackage

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  amo_cmd_t            cmd,
    input  logic [DATA_W-1:0]   old_val,
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    output logic [DATA_W-1:0]   new_val,
    output logic [DATA_W-1:0]   ret_val,
    output logic                do_write
);
    localparam int HW = DATA_W / 2;

    logic [DATA_W-1:0] sum_full;
    logic [HW-1:0]     sum_low;
    logic [DATA_W-1:0] repl;
    logic              match;

    always_comb begin
        sum_full = old_val + opa;
        sum_low  = old_val[HW-1:0] + opa[HW-1:0];
        match    = cmd.wide ? (old_val == opa)
                            : (old_val[HW-1:0] == opa[HW-1:0]);
        repl     = cmd.wide ? opb : {old_val[DATA_W-1:HW], opb[HW-1:0]};
        ret_val  = cmd.wide ? old_val : {{HW{1'b0}}, old_val[HW-1:0]};
        case (cmd.op)
            OP_ADD: begin
                new_val  = cmd.wide ? sum_full : {old_val[DATA_W-1:HW], sum_low};
                do_write = 1'b1;
            end
            OP_CAS: begin
                new_val  = repl;
                do_write = match;
            end
            OP_SWP: begin
                new_val  = repl;
                do_write = 1'b1;
            end
            default: begin
                new_val  = old_val;
                do_write = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/amo_seq.sv
module amo_seq
    import amo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic rsp_ready,
    input  logic need_write,
    output logic accept,
    output logic capture,
    output logic req_ready,
    output logic rsp_valid,
    output logic mem_req,
    output logic mem_we,
    output logic mem_lock
);
    amo_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_READ;
            ST_READ:  state_d = ST_LATCH;
            ST_LATCH: state_d = need_write ? ST_WRITE : ST_RESP;
            ST_WRITE: state_d = ST_RESP;
            ST_RESP:  if (rsp_ready) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign capture   = (state_q == ST_LATCH);
    assign rsp_valid = (state_q == ST_RESP);
    assign mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
    assign mem_we    = (state_q == ST_WRITE);
    assign mem_lock  = (state_q == ST_READ) || (state_q == ST_LATCH) ||
                       (state_q == ST_WRITE);
endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_opa,
    input  logic [DATA_W-1:0] req_opb,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    amo_cmd_t          cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] opa_q, opb_q, new_q, ret_q;
    logic [DATA_W-1:0] alu_new, alu_ret;
    logic              alu_wr, accept, capture;

    amo_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .rsp_ready  (rsp_ready),
        .need_write (alu_wr),
        .accept     (accept),
        .capture    (capture),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_lock   (mem_lock)
    );

    amo_alu #(.DATA_W(DATA_W)) u_alu (
        .cmd      (cmd_q),
        .old_val  (mem_rdata),
        .opa      (opa_q),
        .opb      (opb_q),
        .new_val  (alu_new),
        .ret_val  (alu_ret),
        .do_write (alu_wr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '{op: OP_RSV, wide: 1'b0};
            addr_q <= '0;
            opa_q  <= '0;
            opb_q  <= '0;
            new_q  <= '0;
            ret_q  <= '0;
        end else begin
            if (accept) begin
                cmd_q  <= '{op: amo_op_e'(req_op), wide: req_wide};
                addr_q <= req_addr;
                opa_q  <= req_opa;
                opb_q  <= req_opb;
            end
            if (capture) begin
                new_q <= alu_new;
                ret_q <= alu_ret;
            end
        end
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = new_q;
    assign rsp_data  = ret_q;
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [DATA_W-1:0] rsp_data,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_lock,
    input logic [ADDR_W-1:0] mem_addr
);
    // R6
    write_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> mem_lock);

    // R6
    write_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> $past(mem_lock));

    // R6
    idle_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!mem_lock && !mem_req));

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_lock && $past(mem_lock)) |-> $stable(mem_addr));

    // R7
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    // R8
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !rsp_valid && !mem_lock));
endmodule

bind amo_unit amo_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_lock  (mem_lock),
    .mem_addr  (mem_addr)
);

// File: tb/sim_amo_unit.sv
module sim_amo_unit;
    localparam int AW = 8;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'b00;
    logic          req_wide = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_opa = '0, req_opb = '0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b1;
    logic [DW-1:0] rsp_data;
    logic          mem_req, mem_we, mem_lock;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    always #10 clk = ~clk;

    amo_unit #(.ADDR_W(AW), .DATA_W(DW)) u0 (.*);

    logic [DW-1:0] bmem   [16];
    logic [DW-1:0] shadow [16];

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) bmem[mem_addr[3:0]] <= mem_wdata;
            else        mem_rdata <= bmem[mem_addr[3:0]];
        end
    end

    int n_checks = 0, n_errs = 0;
    int seen_writes = 0, exp_writes = 0;
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) if (!rst && mem_req && mem_we) seen_writes++;

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rsp_valid && rsp_ready) begin
            if (exp_q.size() == 0) check("R6 unexpected response", rsp_data, '0);
            else check(tag_q.pop_front(), rsp_data, exp_q.pop_front());
        end
    end

    // driver: reference model written from the requirements
    task automatic do_op(input string tag, input logic [1:0] op, input logic wide,
                         input int a, input logic [DW-1:0] x, input logic [DW-1:0] y);
        logic [DW-1:0] old, nv, ret;
        logic          wr, eq;
        forever begin
            if (req_ready) break;
            @(posedge clk); #5;
        end
        old = shadow[a];
        ret = wide ? old : {32'h0, old[31:0]};
        eq  = wide ? (old == x) : (old[31:0] == x[31:0]);
        nv  = old;
        wr  = 1'b0;
        case (op)
            2'b00: begin nv = wide ? old + x : {old[63:32], old[31:0] + x[31:0]}; wr = 1'b1; end
            2'b01: begin nv = wide ? y : {old[63:32], y[31:0]}; wr = eq; end
            2'b10: begin nv = wide ? y : {old[63:32], y[31:0]}; wr = 1'b1; end
            default: wr = 1'b0;
        endcase
        if (wr) begin shadow[a] = nv; exp_writes++; end
        exp_q.push_back(ret);
        tag_q.push_back(tag);
        req_op = op; req_wide = wide; req_addr = AW'(a); req_opa = x; req_opb = y;
        req_valid = 1'b1;
        @(posedge clk); #5;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        forever begin
            if (exp_q.size() == 0 && req_ready) break;
            @(posedge clk); #5;
        end
    endtask

    bit done = 1'b0;

    initial begin
        for (int i = 0; i < 16; i++) begin
            bmem[i]   = 64'h0101_0101_0000_0000 * i + 64'h10 * i;
            shadow[i] = bmem[i];
        end
        bmem[2] = 64'h0000_0000_FFFF_FFFF;  shadow[2] = bmem[2];
        bmem[3] = 64'h1234_5678_FFFF_FFFF;  shadow[3] = bmem[3];
        bmem[6] = 64'hAAAA_AAAA_0000_0010;  shadow[6] = bmem[6];
        repeat (3) @(posedge clk);
        #5 rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        check("R8 req_ready", {63'h0, req_ready}, 64'h1);
        check("R8 rsp_valid", {63'h0, rsp_valid}, 64'h0);
        check("R8 mem_req",   {63'h0, mem_req},   64'h0);
        check("R8 mem_lock",  {63'h0, mem_lock},  64'h0);
        @(posedge clk); #5;

        do_op("R1 add wide",             2'b00, 1'b1, 1, 64'd3, 64'd0);
        do_op("R1 add wide carry",       2'b00, 1'b1, 2, 64'd1, 64'd0);
        do_op("R5 add narrow wrap",      2'b00, 1'b0, 3, 64'hFFFF_0000_0000_0002, 64'd0);
        do_op("R2 cas wide hit",         2'b01, 1'b1, 4, shadow[4], 64'hDEAD_BEEF_CAFE_F00D);
        do_op("R3 cas wide miss",        2'b01, 1'b1, 5, 64'h1, 64'h9999);
        do_op("R5 cas narrow low match", 2'b01, 1'b0, 6, 64'h5555_5555_0000_0010, 64'h1111_1111_0000_0077);
        do_op("R3 cas narrow miss",      2'b01, 1'b0, 7, 64'h0, 64'h42);
        do_op("R4 swap wide",            2'b10, 1'b1, 8, 64'd0, 64'h0123_4567_89AB_CDEF);
        do_op("R5 swap narrow",          2'b10, 1'b0, 9, 64'd0, 64'hFFFF_FFFF_8765_4321);
        do_op("R9 reserved code",        2'b11, 1'b1, 10, 64'h5, 64'h6);
        do_op("R1 add repeat a",         2'b00, 1'b1, 11, 64'd7, 64'd0);
        do_op("R1 add repeat b",         2'b00, 1'b1, 11, 64'd7, 64'd0);
        drain();

        // R7 response held under backpressure
        rsp_ready = 1'b0;
        do_op("R7 held swap result", 2'b10, 1'b1, 12, 64'd0, 64'h77);
        for (int k = 0; k < 6; k++) @(negedge clk);
        check("R7 rsp_valid held", {63'h0, rsp_valid}, 64'h1);
        check("R7 rsp_data held", rsp_data, 64'h0101_0101_0000_0000 * 12 + 64'h10 * 12);
        check("R6 lock released while waiting", {63'h0, mem_lock}, 64'h0);
        check("R6 ready low while waiting", {63'h0, req_ready}, 64'h0);
        @(posedge clk); #5;
        rsp_ready = 1'b1;
        drain();
        repeat (2) @(posedge clk);

        for (int i = 1; i <= 12; i++)
            check($sformatf("R6 memory word %0d", i), bmem[i], shadow[i]);
        check("R3 R9 write count", 64'(seen_writes), 64'(exp_writes));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end
endmodule